// File: doc/BRIEF.md
# Embedded Operation Status Reporter

While an internal byte program or erase is under way in a flash-style array, the array cannot serve ordinary reads. This block sits beside the read path and takes the job of answering the host during that time. A command decoder offers it a launch request that carries the operation kind, the byte being programmed and, for a single-sector erase, the sector number. From the edge that accepts the request, a countdown stands in for the time the operation takes. While that countdown runs, every host read returns a status byte instead of array data. Once the countdown ends, reads pass through to the array again.

The status byte carries two independent ways to detect completion. Bit 7 is a polling bit: during a program it holds the inverse of the written byte's bit 7, and during any erase it reads 0, because a finished erase leaves FFh. Bit 6 is a toggle bit: it changes value after every read access made while the operation runs, and it stops changing when the operation ends. A whole-array erase is sequenced one sector at a time, in ascending order, and each sector is filled with zeros before it is erased. The current sector and phase are shown on output pins so the array side can follow.

The launch interface uses valid/ready. `op_ready` is high exactly when no operation is running. An offer that is made while `op_ready` is low is not taken and has no effect, so a program attempt made during an erase is dropped. The upstream side may hold its offer until `op_ready` rises or may withdraw it. Host reads use no handshake: `rd_data` is valid in every cycle.

Top module: `embop_status_rpt`

## Requirements
- R1: After reset, `busy`, `done`, `erase_op` and `zero_fill` are 0, `op_ready` is 1, and `rd_data` equals `array_rdata`.
- R2: A launch is accepted on a rising clock edge where `op_valid` and `op_ready` are both high. `op_ready` is low in every cycle where `busy` is high. An offer made while busy, including a program offered during an erase, is ignored.
- R3: A program (`op_kind` = 2'b00) keeps `busy` high for exactly PROG_CYCLES cycles, starting with the cycle after the accepting edge.
- R4: While a program runs, `rd_data[7]` equals the inverse of bit 7 of `op_byte` as it was sampled at acceptance.
- R5: While any erase runs, `rd_data[7]` is 0.
- R6: `rd_data[6]` is 0 in the first busy cycle. It inverts after each busy cycle in which `rd_en` is high, and holds its value across busy cycles in which `rd_en` is low.
- R7: While busy, `rd_data[5:0]` is 0.
- R8: `done` is high for exactly one cycle, which is the last busy cycle. From the next cycle on, `rd_data` equals `array_rdata`.
- R9: A sector erase (`op_kind` = 2'b01) keeps `busy` and `erase_op` high for SECT_ERASE_CYCLES cycles, with `cur_sector` equal to `op_sector` as sampled at acceptance and `zero_fill` low.
- R10: A chip erase (`op_kind` = 2'b10) visits sectors 0 to 2^SECT_W-1 in ascending order. For each sector, `zero_fill` is high for ZERO_CYCLES cycles, then low for SECT_ERASE_CYCLES cycles. `erase_op` stays high throughout.
- R11: `op_kind` = 2'b11 is accepted when ready but starts nothing: `busy` stays low and reads keep passing through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Launch request offered |
| op_ready | output | 1 | Launch can be accepted (no operation running) |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 none |
| op_byte | input | 8 | Byte being programmed |
| op_sector | input | SECT_W | Target sector for a sector erase |
| rd_en | input | 1 | Host read access in this cycle |
| array_rdata | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data returned to the host |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse in the last busy cycle |
| erase_op | output | 1 | Running operation is an erase |
| zero_fill | output | 1 | Chip erase is in its zero-fill phase |
| cur_sector | output | SECT_W | Sector being worked on by an erase |

## Verification
Program launches are made with written bytes whose bit 7 is set and with bytes whose bit 7 is clear. This shows whether the polling bit is really inverted rather than forced to a constant. Reads during busy periods come as a steady stream, as alternating cycles and as random gaps, which separates a toggle that follows read accesses from one that follows the clock. Sector erases at several sector numbers, a full chip erase, offers made while busy, a held offer that lands right after completion, and the unused operation code each test the handshake, the sector walk and the timing of the end of an operation against a queue-based model.

// File: rtl/embop_pkg.sv
package embop_pkg;
  typedef enum logic [1:0] {
    OPK_PROG = 2'b00,
    OPK_SECT = 2'b01,
    OPK_CHIP = 2'b10,
    OPK_NONE = 2'b11
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_SECT,
    ST_ZERO,
    ST_WIPE
  } run_st_e;

  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
endpackage

// File: rtl/embop_timer.sv
module embop_timer
  import embop_pkg::*;
#(
  parameter int unsigned PROG_CYCLES       = 20,
  parameter int unsigned ZERO_CYCLES       = 4,
  parameter int unsigned SECT_ERASE_CYCLES = 50,
  parameter int unsigned SECT_W            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_kind_e          kind,
  input  logic [SECT_W-1:0] sect_in,
  output logic              busy,
  output logic              last,
  output logic              erase_op,
  output logic              zero_fill,
  output logic [SECT_W-1:0] cur_sector
);
  localparam int unsigned MAX_PZ = (PROG_CYCLES > ZERO_CYCLES) ? PROG_CYCLES : ZERO_CYCLES;
  localparam int unsigned MAXD   = (MAX_PZ > SECT_ERASE_CYCLES) ? MAX_PZ : SECT_ERASE_CYCLES;
  localparam int unsigned CNT_W  = $clog2(MAXD + 1);
  localparam logic [CNT_W-1:0] LD_PROG = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_ZERO = CNT_W'(ZERO_CYCLES - 1);
  localparam logic [CNT_W-1:0] LD_WIPE = CNT_W'(SECT_ERASE_CYCLES - 1);

  run_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [SECT_W-1:0] sect;
  logic              cnt_zero;
  logic              top_sect;

  assign cnt_zero = (cnt == '0);
  assign top_sect = &sect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      sect <= '0;
    end else if (st == ST_IDLE) begin
      if (launch) begin
        case (kind)
          OPK_PROG: begin st <= ST_PROG; cnt <= LD_PROG; end
          OPK_SECT: begin st <= ST_SECT; cnt <= LD_WIPE; sect <= sect_in; end
          OPK_CHIP: begin st <= ST_ZERO; cnt <= LD_ZERO; sect <= '0; end
          default:  st <= ST_IDLE;
        endcase
      end
    end else if (!cnt_zero) begin
      cnt <= cnt - CNT_W'(1);
    end else begin
      case (st)
        ST_ZERO: begin st <= ST_WIPE; cnt <= LD_WIPE; end
        ST_WIPE: begin
          if (top_sect) begin
            st <= ST_IDLE;
          end else begin
            st   <= ST_ZERO;
            cnt  <= LD_ZERO;
            sect <= sect + SECT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign erase_op   = (st == ST_SECT) || (st == ST_ZERO) || (st == ST_WIPE);
  assign zero_fill  = (st == ST_ZERO);
  assign cur_sector = sect;
  assign last       = cnt_zero && ((st == ST_PROG) || (st == ST_SECT) ||
                                   ((st == ST_WIPE) && top_sect));
endmodule

// File: rtl/embop_status.sv
module embop_status
  import embop_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_b7,
  input  logic          busy,
  input  logic          erase_op,
  input  logic          rd_en,
  input  logic [DW-1:0] array_rdata,
  output logic [DW-1:0] rd_data
);
  logic          tog;
  logic          inv7;
  logic [DW-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog  <= 1'b0;
      inv7 <= 1'b0;
    end else if (launch) begin
      tog  <= 1'b0;
      inv7 <= ~launch_b7;
    end else if (busy && rd_en) begin
      tog <= ~tog;
    end
  end

  always_comb begin
    status           = '0;
    status[BIT_POLL] = erase_op ? 1'b0 : inv7;
    status[BIT_TOG]  = tog;
    rd_data          = busy ? status : array_rdata;
  end
endmodule

// File: rtl/embop_status_rpt.sv
module embop_status_rpt
  import embop_pkg::*;
#(
  parameter int unsigned PROG_CYCLES       = 20,
  parameter int unsigned ZERO_CYCLES       = 4,
  parameter int unsigned SECT_ERASE_CYCLES = 50,
  parameter int unsigned SECT_W            = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic [7:0]        op_byte,
  input  logic [SECT_W-1:0] op_sector,
  input  logic              rd_en,
  input  logic [7:0]        array_rdata,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              erase_op,
  output logic              zero_fill,
  output logic [SECT_W-1:0] cur_sector
);
  op_kind_e kind;
  logic     launch;
  logic     last;

  assign kind     = op_kind_e'(op_kind);
  assign op_ready = !busy;
  assign launch   = op_valid && op_ready && (kind != OPK_NONE);
  assign done     = last;

  embop_timer #(
    .PROG_CYCLES      (PROG_CYCLES),
    .ZERO_CYCLES      (ZERO_CYCLES),
    .SECT_ERASE_CYCLES(SECT_ERASE_CYCLES),
    .SECT_W           (SECT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .kind      (kind),
    .sect_in   (op_sector),
    .busy      (busy),
    .last      (last),
    .erase_op  (erase_op),
    .zero_fill (zero_fill),
    .cur_sector(cur_sector)
  );

  embop_status #(.DW(8)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_b7  (op_byte[BIT_POLL]),
    .busy       (busy),
    .erase_op   (erase_op),
    .rd_en      (rd_en),
    .array_rdata(array_rdata),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/embop_status_rpt_chk.sv
module embop_status_rpt_chk #(
  parameter int unsigned SECT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              busy,
  input logic              done,
  input logic              erase_op,
  input logic              zero_fill,
  input logic [SECT_W-1:0] cur_sector
);
  AST_DONE_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);  // R8
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R8
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_valid && op_ready));  // R2
  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && erase_op) |-> !rd_data[7]);  // R5
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_data[5:0] == 6'd0));  // R7
  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(rd_en)) |-> $stable(rd_data[6]));  // R6
  AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !zero_fill) |-> $stable(cur_sector));  // R9
  AST_ZERO_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    zero_fill |-> (erase_op && busy));  // R10
endmodule

bind embop_status_rpt embop_status_rpt_chk #(.SECT_W(SECT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .busy      (busy),
  .done      (done),
  .erase_op  (erase_op),
  .zero_fill (zero_fill),
  .cur_sector(cur_sector)
);

// File: tb/embop_status_rpt_test.sv
module embop_status_rpt_test;
  localparam int unsigned P  = 5;
  localparam int unsigned Z  = 3;
  localparam int unsigned E  = 7;
  localparam int unsigned SW = 2;
  localparam int unsigned NS = 1 << SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = 2'b00;
  logic [7:0]    op_byte = 8'h00;
  logic [SW-1:0] op_sector = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    array_rdata = 8'h5A;
  logic          op_ready, busy, done, erase_op, zero_fill;
  logic [7:0]    rd_data;
  logic [SW-1:0] cur_sector;

  always #4 clk = ~clk;

  embop_status_rpt #(
    .PROG_CYCLES(P), .ZERO_CYCLES(Z), .SECT_ERASE_CYCLES(E), .SECT_W(SW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_byte(op_byte), .op_sector(op_sector),
    .rd_en(rd_en), .array_rdata(array_rdata), .rd_data(rd_data),
    .busy(busy), .done(done), .erase_op(erase_op), .zero_fill(zero_fill),
    .cur_sector(cur_sector)
  );

  typedef struct packed {
    logic          er;
    logic          zf;
    logic [SW-1:0] sec;
  } slot_t;

  slot_t q[$];
  logic  m_tog = 1'b0;
  logic  m_inv7 = 1'b0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  // Reference model: one queue slot per expected busy cycle.
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_tog = 1'b0;
    end else if (q.size() > 0) begin
      if (rd_en) m_tog = ~m_tog;
      void'(q.pop_front());
    end else if (op_valid && op_kind != 2'b11) begin
      m_tog  = 1'b0;
      m_inv7 = ~op_byte[7];
      case (op_kind)
        2'b00: repeat (P) q.push_back('{1'b0, 1'b0, '0});
        2'b01: repeat (E) q.push_back('{1'b1, 1'b0, op_sector});
        default: begin
          for (int s = 0; s < NS; s++) begin
            repeat (Z) q.push_back('{1'b1, 1'b1, SW'(s)});
            repeat (E) q.push_back('{1'b1, 1'b0, SW'(s)});
          end
        end
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model every cycle, after the negedge drive settles.
  always @(negedge clk) begin
    #2;
    if (!finished) begin
      if (q.size() > 0) begin
        chk("R3", "busy", busy, 1);
        chk("R2", "op_ready", op_ready, 0);
        chk("R8", "done", done, q.size() == 1);
        chk(q[0].er ? "R5" : "R4", "poll bit7", rd_data[7], q[0].er ? 0 : m_inv7);
        chk("R6", "toggle bit6", rd_data[6], m_tog);
        chk("R7", "low bits", rd_data[5:0], 0);
        chk("R9", "erase_op", erase_op, q[0].er);
        chk("R10", "zero_fill", zero_fill, q[0].zf);
        if (q[0].er) chk("R10", "cur_sector", cur_sector, q[0].sec);
      end else begin
        chk("R3", "busy idle", busy, 0);
        chk("R2", "op_ready idle", op_ready, 1);
        chk("R8", "done idle", done, 0);
        chk("R8", "pass-through", rd_data, array_rdata);
        chk("R1", "erase_op idle", erase_op, 0);
        chk("R1", "zero_fill idle", zero_fill, 0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // rd_mode: 0 none, 1 every cycle, 2 alternating, 3 random
  task automatic cycles(input int n, input int rd_mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      array_rdata = 8'($urandom);
      case (rd_mode)
        1: rd_en = 1'b1;
        2: rd_en = i[0];
        3: rd_en = 1'($urandom);
        default: rd_en = 1'b0;
      endcase
    end
  endtask

  task automatic offer(input logic [1:0] k, input logic [7:0] b, input logic [SW-1:0] s);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_byte = b; op_sector = s;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state at the ports
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset ready", op_ready, 1);
    chk("R1", "reset rd_data", rd_data, 8'h5A);
    rst_n = 1'b1;
    cycles(2, 1);

    // R3 R4 R6: program with bit7 clear, alternating reads
    offer(2'b00, 8'h3C, '0);
    cycles(P + 3, 2);
    // R4: program with bit7 set, read every cycle
    offer(2'b00, 8'hA5, '0);
    cycles(P + 3, 1);

    // R9 + R2: sector erase, program offers during erase are ignored
    offer(2'b01, 8'h00, SW'(2));
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'b00; op_byte = 8'h00;
    cycles(E - 3, 3);
    op_valid = 1'b0;
    @(negedge clk);
    #2;
    chk("R2", "ignored program during erase keeps erase_op", erase_op, busy ? 1 : 0);
    cycles(6, 3);
    offer(2'b01, 8'hFF, SW'(NS - 1));
    cycles(E + 2, 0);

    // R10: full chip erase with random reads
    offer(2'b10, 8'h81, SW'(1));
    cycles(NS * (Z + E) + 3, 3);

    // R11: unused code starts nothing
    offer(2'b11, 8'h00, '0);
    #2;
    chk("R11", "busy after unused code", busy, 0);
    cycles(3, 1);

    // R2 R8: offer held across completion is taken right after done
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'b00; op_byte = 8'h80;
    cycles(P + 1, 1);
    op_kind = 2'b01; op_sector = SW'(1);
    cycles(1, 1);
    op_valid = 1'b0;
    cycles(E + P + 4, 2);

    summary();
  end
endmodule